// File: doc/BRIEF.md
# Predicated Vector Load Sequencer

This block steps a single immediate-offset load instruction across the elements of a register vector. On a one-cycle `start` it captures a base register number, a destination register number, a vector/scalar flag for each, a signed immediate, a source predicate mask, a destination predicate mask, a vector length and an update flag. It then walks the active elements one at a time. For each one it reads the base value through a register-file read port and forms an effective address. It issues that address on a valid/ready memory read request and writes the returned word into the destination register element. In update mode it also writes the address back into the base register element.

The operand flags select the addressing form. With a vector base, each element has its own base register (indirect addressing). With a scalar base and a vector destination, one base value is stepped by the immediate for each destination element (strided addressing). With both operands scalar, one plain base-plus-offset load is made. Element numbers are added to the register numbers and wrap modulo the register count, which must be a power of two. A vector length above the mask width is clamped to the mask width. The sequence finishes with a one-cycle `done` pulse.

Top module: `vload_seq`

## Requirements
- R1: With both operands scalar, exactly one read is issued, at address reg[base] + imm, and the response is written to reg[dest]. The vector length and both masks are ignored.
- R2: With a vector base, element i reads from address reg[base+i] + imm.
- R3: With a scalar base and a vector destination, destination element j reads from origin + j*imm. The origin is the base register value read on the first element, and j is the destination element number.
- R4: With a vector destination, the destination index skips every element whose bit in `dst_mask` (bit j for element j) is 0. No read and no write is made for a skipped element. The source and destination indices skip on their own masks independently.
- R5: With a vector base, the source index skips every element whose bit in `src_mask` (bit i for element i) is 0. The source index advances only when the base is a vector, and the destination index advances only when the destination is a vector.
- R6: When `upd_en` is 1, after the data write the effective address is written to reg[base+i] in indirect mode, or to reg[base] otherwise. If the two writes hit the same register, the address write lands last.
- R7: In strided mode with update, every address is still formed from the original origin, and reg[base] ends holding the last address.
- R8: With a scalar destination, the sequence ends after the first completed load, even when the base is a vector. In that case the load uses the first active source element.
- R9: The sequence ends without a further read as soon as an active vector index reaches the clamped vector length while skipping. With no active element, `done` comes with no read at all.
- R10: A request keeps `mem_req_valid` high and its address stable until `mem_req_ready`. After an accepted request, no new request is made until its response has arrived.
- R11: After reset, `busy`, `done`, `mem_req_valid` and `rf_wr_en` are 0. `busy` is 1 from the cycle after an accepted `start` until the sequence ends. `done` is a single-cycle pulse that coincides with `busy` falling. `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| base_reg | input | RW | Base register number |
| base_vec | input | 1 | Base operand is a vector |
| dest_reg | input | RW | Destination register number |
| dest_vec | input | 1 | Destination operand is a vector |
| imm | input | XLEN | Signed immediate offset or stride |
| src_mask | input | MAXVL | Source element predicate |
| dst_mask | input | MAXVL | Destination element predicate |
| vl | input | IW | Vector length |
| upd_en | input | 1 | Write the effective address back to the base |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| rf_rd_addr | output | RW | Register-file read address |
| rf_rd_data | input | XLEN | Register-file read data (same cycle) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_addr | output | RW | Register-file write address |
| rf_wr_data | output | XLEN | Register-file write data |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | XLEN | Memory read address |
| mem_rsp_valid | input | 1 | Memory read response strobe |
| mem_rsp_data | input | XLEN | Memory read response data |

## Verification
On every cycle the assertions check several properties. The request handshake must hold and allow only one read in flight. `done` must be a lone pulse that comes only with the block idle. Each issued read must sit on an element whose predicate bit is set and whose index is below the vector length. The skip logic must never choose an element outside its search window. Only the bench's scenarios can show the addresses themselves and the final register contents for each addressing form. They also show the number of reads under different mask and length patterns, the effect of update mode (including the final strided base value) and that a second `start` during a run changes nothing.

// File: rtl/vls_pkg.sv
package vls_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEEK,
        S_ADDR,
        S_REQ,
        S_WAIT,
        S_UPD,
        S_NEXT
    } seq_state_e;

    typedef enum logic [1:0] {
        AM_SCALAR,
        AM_INDIRECT,
        AM_STRIDE
    } amode_e;

    function automatic amode_e pick_mode(input logic bvec, input logic dvec);
        if (bvec)
            return AM_INDIRECT;
        else if (dvec)
            return AM_STRIDE;
        else
            return AM_SCALAR;
    endfunction

endpackage

// File: rtl/vls_find_next.sv
// Finds the lowest set mask bit at or above 'from' and below 'limit'.
module vls_find_next #(
    parameter int N  = 8,
    parameter int IW = 4
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] from,
    input  logic [IW-1:0] limit,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N-1:0] cand;

    for (genvar k = 0; k < N; k++) begin : g_cand
        assign cand[k] = mask[k] && (IW'(k) >= from) && (IW'(k) < limit);
    end

    always_comb begin
        found = |cand;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (cand[k]) idx = IW'(k);
        end
    end

    // R9: a chosen element always lies inside the search window
    always_comb begin
        if (found) begin
            a_r9_pick_in_window: assert (idx >= from && idx < limit);
        end
    end

endmodule

// File: rtl/vls_agen.sv
// Effective address generation for the three addressing forms.
module vls_agen #(
    parameter int XLEN = 32,
    parameter int IW   = 4
) (
    input  vls_pkg::amode_e   mode,
    input  logic              first,
    input  logic [XLEN-1:0]   rd_data,
    input  logic [XLEN-1:0]   hold,
    input  logic [XLEN-1:0]   imm,
    input  logic [IW-1:0]     step,
    output logic [XLEN-1:0]   ea,
    output logic [XLEN-1:0]   next_hold
);
    import vls_pkg::*;

    logic [XLEN-1:0] origin;

    always_comb begin
        origin = first ? rd_data : hold;
        case (mode)
            AM_STRIDE: begin
                ea        = origin + XLEN'(step) * imm;
                next_hold = origin;
            end
            AM_INDIRECT: begin
                ea        = rd_data + imm;
                next_hold = hold;
            end
            default: begin
                ea        = rd_data + imm;
                next_hold = hold;
            end
        endcase
    end

endmodule

// File: rtl/vload_seq.sv
module vload_seq #(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int MAXVL = 8,
    localparam int RW   = $clog2(NREG),
    localparam int IW   = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RW-1:0]    base_reg,
    input  logic             base_vec,
    input  logic [RW-1:0]    dest_reg,
    input  logic             dest_vec,
    input  logic [XLEN-1:0]  imm,
    input  logic [MAXVL-1:0] src_mask,
    input  logic [MAXVL-1:0] dst_mask,
    input  logic [IW-1:0]    vl,
    input  logic             upd_en,
    output logic             busy,
    output logic             done,
    output logic [RW-1:0]    rf_rd_addr,
    input  logic [XLEN-1:0]  rf_rd_data,
    output logic             rf_wr_en,
    output logic [RW-1:0]    rf_wr_addr,
    output logic [XLEN-1:0]  rf_wr_data,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [XLEN-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [XLEN-1:0]  mem_rsp_data
);
    import vls_pkg::*;

    typedef struct packed {
        seq_state_e       st;
        logic [RW-1:0]    breg;
        logic [RW-1:0]    dreg;
        logic             bvec;
        logic             dvec;
        logic             upd;
        logic [XLEN-1:0]  imm;
        logic [XLEN-1:0]  ea;
        logic [XLEN-1:0]  hold;
        logic [MAXVL-1:0] smask;
        logic [MAXVL-1:0] dmask;
        logic [IW-1:0]    vl;
        logic [IW-1:0]    i;
        logic [IW-1:0]    j;
        logic             first;
        logic             done;
    } seq_t;

    seq_t q, d;

    // element register numbers
    logic [RW-1:0]   base_elem;
    logic [RW-1:0]   dest_elem;
    logic            src_found, dst_found;
    logic [IW-1:0]   src_idx, dst_idx;
    logic [XLEN-1:0] agen_ea, agen_hold;
    amode_e          mode;
    logic            seek_end;
    logic [IW-1:0]   vl_clamped;

    assign mode       = pick_mode(q.bvec, q.dvec);
    assign base_elem  = q.breg + (q.bvec ? RW'(q.i) : RW'(0));
    assign dest_elem  = q.dreg + (q.dvec ? RW'(q.j) : RW'(0));
    assign vl_clamped = (vl > IW'(MAXVL)) ? IW'(MAXVL) : vl;

    vls_find_next #(.N(MAXVL), .IW(IW)) u_src_seek (
        .mask  (q.smask),
        .from  (q.i),
        .limit (q.vl),
        .found (src_found),
        .idx   (src_idx)
    );

    vls_find_next #(.N(MAXVL), .IW(IW)) u_dst_seek (
        .mask  (q.dmask),
        .from  (q.j),
        .limit (q.vl),
        .found (dst_found),
        .idx   (dst_idx)
    );

    vls_agen #(.XLEN(XLEN), .IW(IW)) u_agen (
        .mode      (mode),
        .first     (q.first),
        .rd_data   (rf_rd_data),
        .hold      (q.hold),
        .imm       (q.imm),
        .step      (q.j),
        .ea        (agen_ea),
        .next_hold (agen_hold)
    );

    assign seek_end = (q.bvec && !src_found) || (q.dvec && !dst_found);

    always_comb begin
        d             = q;
        d.done        = 1'b0;
        rf_rd_addr    = base_elem;
        rf_wr_en      = 1'b0;
        rf_wr_addr    = '0;
        rf_wr_data    = '0;
        mem_req_valid = (q.st == S_REQ);
        mem_req_addr  = q.ea;

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.breg  = base_reg;
                    d.dreg  = dest_reg;
                    d.bvec  = base_vec;
                    d.dvec  = dest_vec;
                    d.upd   = upd_en;
                    d.imm   = imm;
                    d.smask = src_mask;
                    d.dmask = dst_mask;
                    d.vl    = vl_clamped;
                    d.i     = '0;
                    d.j     = '0;
                    d.first = 1'b1;
                    d.st    = S_SEEK;
                end
            end
            S_SEEK: begin
                if (seek_end) begin
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end else begin
                    if (q.bvec) d.i = src_idx;
                    if (q.dvec) d.j = dst_idx;
                    d.st = S_ADDR;
                end
            end
            S_ADDR: begin
                d.ea    = agen_ea;
                d.hold  = agen_hold;
                d.first = 1'b0;
                d.st    = S_REQ;
            end
            S_REQ: begin
                if (mem_req_ready) d.st = S_WAIT;
            end
            S_WAIT: begin
                if (mem_rsp_valid) begin
                    rf_wr_en   = 1'b1;
                    rf_wr_addr = dest_elem;
                    rf_wr_data = mem_rsp_data;
                    d.st       = q.upd ? S_UPD : S_NEXT;
                end
            end
            S_UPD: begin
                rf_wr_en   = 1'b1;
                rf_wr_addr = base_elem;
                rf_wr_data = q.ea;
                d.st       = S_NEXT;
            end
            S_NEXT: begin
                if (!q.dvec) begin
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end else begin
                    d.i  = q.i + IW'(q.bvec);
                    d.j  = q.j + IW'(1);
                    d.st = S_SEEK;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = (q.st != S_IDLE);
    assign done = q.done;

    // R10: a pending request holds its address until accepted
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R10: no second request right behind an accepted one
    a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: done only with the block idle
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: a vector destination never reads beyond the vector length
    a_r9_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && q.dvec |-> q.j < q.vl);

    // R4: a read only for an enabled destination element
    a_r4_dst_active: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && q.dvec |-> |(q.dmask & (MAXVL'(1) << q.j)));

    // R5: a read only for an enabled source element
    a_r5_src_active: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && q.bvec |-> |(q.smask & (MAXVL'(1) << q.i)));

endmodule

// File: tb/vload_seq_test.sv
module vload_seq_test;

    localparam logic [31:0] KEY = 32'h5A5A_0000;

    typedef struct packed {
        logic [23:0] req;
        logic [4:0]  b;
        logic        bv;
        logic [4:0]  d;
        logic        dv;
        logic [31:0] imm;
        logic [7:0]  sm;
        logic [7:0]  dm;
        logic [3:0]  vl;
        logic        upd;
        logic [3:0]  nload;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{"R1 ", 5'd3,  1'b0, 5'd10, 1'b0, 32'h0000_0008, 8'h00, 8'h00, 4'd0, 1'b0, 4'd1},
        '{"R6 ", 5'd5,  1'b0, 5'd11, 1'b0, 32'hFFFF_FFFC, 8'hFF, 8'hFF, 4'd3, 1'b1, 4'd1},
        '{"R2 ", 5'd4,  1'b1, 5'd16, 1'b1, 32'h0000_0010, 8'hFF, 8'hFF, 4'd4, 1'b0, 4'd4},
        '{"R5 ", 5'd4,  1'b1, 5'd16, 1'b1, 32'h0000_0004, 8'hA5, 8'hFF, 4'd8, 1'b0, 4'd4},
        '{"R3 ", 5'd2,  1'b0, 5'd20, 1'b1, 32'h0000_0020, 8'h00, 8'hFF, 4'd5, 1'b0, 4'd5},
        '{"R4 ", 5'd2,  1'b0, 5'd20, 1'b1, 32'h0000_0020, 8'h00, 8'h69, 4'd8, 1'b0, 4'd4},
        '{"R7 ", 5'd2,  1'b0, 5'd24, 1'b1, 32'hFFFF_FFF8, 8'h00, 8'h0F, 4'd4, 1'b1, 4'd4},
        '{"R6 ", 5'd8,  1'b1, 5'd12, 1'b1, 32'h0000_0100, 8'hFF, 8'hFF, 4'd3, 1'b1, 4'd3},
        '{"R8 ", 5'd4,  1'b1, 5'd9,  1'b0, 32'h0000_0002, 8'h04, 8'h00, 4'd8, 1'b0, 4'd1},
        '{"R9 ", 5'd1,  1'b0, 5'd20, 1'b1, 32'h0000_0004, 8'hFF, 8'hFF, 4'd0, 1'b0, 4'd0},
        '{"R9 ", 5'd4,  1'b1, 5'd20, 1'b1, 32'h0000_0004, 8'h00, 8'hFF, 4'd8, 1'b0, 4'd0},
        '{"R9 ", 5'd2,  1'b0, 5'd20, 1'b1, 32'h0000_0004, 8'h00, 8'hF0, 4'd4, 1'b0, 4'd0},
        '{"R9 ", 5'd6,  1'b0, 5'd24, 1'b1, 32'h0000_000C, 8'h00, 8'hFF, 4'd8, 1'b0, 4'd8},
        '{"R4 ", 5'd0,  1'b1, 5'd16, 1'b1, 32'h0000_0001, 8'hFF, 8'hF0, 4'd8, 1'b0, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  base_reg = '0;
    logic        base_vec = 1'b0;
    logic [4:0]  dest_reg = '0;
    logic        dest_vec = 1'b0;
    logic [31:0] imm = '0;
    logic [7:0]  src_mask = '0;
    logic [7:0]  dst_mask = '0;
    logic [3:0]  vl = '0;
    logic        upd_en = 1'b0;
    logic        busy, done;
    logic [4:0]  rf_rd_addr, rf_wr_addr;
    logic [31:0] rf_rd_data, rf_wr_data;
    logic        rf_wr_en;
    logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [31:0] mem_req_addr, mem_rsp_data;

    always #4 clk = ~clk;

    vload_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base_reg(base_reg), .base_vec(base_vec), .dest_reg(dest_reg), .dest_vec(dest_vec),
        .imm(imm), .src_mask(src_mask), .dst_mask(dst_mask), .vl(vl), .upd_en(upd_en),
        .busy(busy), .done(done),
        .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // register file model
    logic [31:0] rf [32];
    assign rf_rd_data = rf[rf_rd_addr];
    always @(posedge clk) begin
        if (rf_wr_en) rf[rf_wr_addr] <= rf_wr_data;
    end

    // memory model: optional stalls, fixed response latency
    logic        stall_en = 1'b1;
    logic        rdy;
    int          lat;
    int          n_log;
    int          hs_viol;
    logic [31:0] log_addr [512];
    logic [31:0] rsp_r;
    logic        prev_wait;
    logic [31:0] prev_addr;

    assign mem_req_ready = rdy;
    assign mem_rsp_valid = (lat == 1);
    assign mem_rsp_data  = rsp_r;

    always @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b0; lat <= 0; n_log <= 0; hs_viol <= 0;
            prev_wait <= 1'b0; prev_addr <= '0; rsp_r <= '0;
        end else begin
            if (mem_req_valid && mem_req_ready) begin
                if (lat != 0) hs_viol <= hs_viol + 1;
                log_addr[n_log[8:0]] <= mem_req_addr;
                n_log <= n_log + 1;
                lat   <= 2;
                rsp_r <= mem_req_addr ^ KEY;
            end else if (lat != 0) begin
                lat <= lat - 1;
            end
            if (prev_wait && (!mem_req_valid || mem_req_addr != prev_addr))
                hs_viol <= hs_viol + 1;
            prev_wait <= mem_req_valid && !mem_req_ready;
            prev_addr <= mem_req_addr;
            rdy <= stall_en ? ~rdy : 1'b1;
        end
    end

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected-result model built from the requirements
    logic [31:0] exp_rf   [32];
    logic [31:0] exp_addr [16];
    int          exp_n;

    task automatic model(input vec_t v);
        int i = 0;
        int j = 0;
        logic [31:0] origin = exp_rf[v.b];
        logic [31:0] ea;
        int lim = (v.vl > 8) ? 8 : int'(v.vl);
        exp_n = 0;
        forever begin
            if (v.bv) begin
                while (i < lim && !v.sm[i]) i++;
                if (i >= lim) break;
            end
            if (v.dv) begin
                while (j < lim && !v.dm[j]) j++;
                if (j >= lim) break;
            end
            if (v.bv)      ea = exp_rf[5'(v.b + 5'(i))] + v.imm;
            else if (v.dv) ea = origin + 32'(j) * v.imm;
            else           ea = exp_rf[v.b] + v.imm;
            exp_addr[exp_n] = ea;
            exp_n++;
            exp_rf[5'(v.d + (v.dv ? 5'(j) : 5'd0))] = ea ^ KEY;
            if (v.upd) exp_rf[5'(v.b + (v.bv ? 5'(i) : 5'd0))] = ea;
            if (!v.dv) break;
            if (v.bv) i++;
            j++;
        end
    endtask

    task automatic init_rf();
        for (int k = 0; k < 32; k++) begin
            rf[k]     = 32'h1000 + 32'(k) * 32'h40;
            exp_rf[k] = 32'h1000 + 32'(k) * 32'h40;
        end
    endtask

    task automatic drive(input vec_t v);
        base_reg = v.b; base_vec = v.bv; dest_reg = v.d; dest_vec = v.dv;
        imm = v.imm; src_mask = v.sm; dst_mask = v.dm; vl = v.vl; upd_en = v.upd;
    endtask

    // run one operation; optionally pulse start again mid-run with other operands
    task automatic run(input vec_t v, input bit restart, input vec_t other);
        string tag = string'(v.req);
        int first_log;
        int waited = 0;
        init_rf();
        model(v);
        @(negedge clk);
        first_log = n_log;
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R11", "busy after start", 32'(busy), 32'd1);
        if (restart) begin
            @(negedge clk);
            drive(other);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1 && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        check(done === 1'b1, "R11", "done seen", 32'(done), 32'd1);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R11", "done single pulse, idle",
              {30'd0, done, busy}, 32'd0);
        check(n_log - first_log == exp_n && exp_n == int'(v.nload), tag, "load count",
              32'(n_log - first_log), 32'(v.nload));
        for (int k = 0; k < exp_n && k < n_log - first_log; k++)
            check(log_addr[9'(first_log + k)] === exp_addr[k], tag, "address",
                  log_addr[9'(first_log + k)], exp_addr[k]);
        begin
            int bad = -1;
            for (int k = 0; k < 32; k++)
                if (bad < 0 && rf[k] !== exp_rf[k]) bad = k;
            if (bad < 0) check(1'b1, tag, "register file", 32'd0, 32'd0);
            else         check(1'b0, tag, "register file word", rf[bad], exp_rf[bad]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog expired: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        init_rf();
        repeat (3) @(negedge clk);
        // R11: reset state
        check(busy === 1'b0 && done === 1'b0 && mem_req_valid === 1'b0 && rf_wr_en === 1'b0,
              "R11", "reset outputs", {28'd0, busy, done, mem_req_valid, rf_wr_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && mem_req_valid === 1'b0, "R11", "idle after reset",
              {30'd0, busy, mem_req_valid}, 32'd0);

        // table walk with a stalling memory (R1..R9)
        for (int n = 0; n < NV; n++) run(VECS[n], 1'b0, VECS[0]);

        // same table without stalls
        stall_en = 1'b0;
        for (int n = 0; n < NV; n++) run(VECS[n], 1'b0, VECS[0]);

        // R11: a second start during a run is ignored
        stall_en = 1'b1;
        run(VECS[2], 1'b1, VECS[0]);
        run(VECS[6], 1'b1, VECS[12]);

        // R1: scalar load with a vector length above the mask width
        run('{"R1 ", 5'd31, 1'b0, 5'd0, 1'b0, 32'h8000_0000, 8'h00, 8'h00, 4'd15, 1'b1, 4'd1},
            1'b0, VECS[0]);

        // R6/R7: update where base and destination registers coincide
        run('{"R6 ", 5'd7, 1'b1, 5'd7, 1'b1, 32'h0000_0040, 8'h3C, 8'hFF, 4'd8, 1'b1, 4'd4},
            1'b0, VECS[0]);
        run('{"R7 ", 5'd30, 1'b0, 5'd30, 1'b1, 32'h0000_0010, 8'h00, 8'h81, 4'd8, 1'b1, 4'd2},
            1'b0, VECS[0]);

        // R10: handshake held and single outstanding across every run
        check(hs_viol == 0, "R10", "handshake violations", 32'(hs_viol), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule